// File: doc/BRIEF.md
# SPI Byte Port with Overrun Tracking

This block is the 8-bit data path of a CPU-attached SPI peripheral. It runs either as bus master or as bus slave, selected by a static mode input. The CPU sees two register addresses. The data address is shared: a write there lands in the transmit shift register, and a read there returns the receive buffer. The status address reports three flags: transfer complete, write collision and overrun.

In master mode, a CPU write to the data address launches an 8-bit exchange. The SCLK comes from a divider: each high phase and each low phase lasts `HALF_DIV` system clocks. In slave mode, the shift register follows an external SCLK and slave-select. Both are synchronised into the system clock domain first.

Every completed byte is copied into the receive buffer and sets the complete flag. The one exception is when software has not yet acknowledged the previous byte: the new byte is then thrown away and the overrun flag is raised.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the status register (address 1) reads 00h and the receive buffer (address 0) reads 00h. `sclk_out`, `mosi_out` and `miso_out` are all low.
- R2: Address 0 is shared. A CPU write loads the transmit shift register and a CPU read returns the receive buffer. In master mode the write starts an exchange of exactly 8 bits, most significant bit first, with 8 SCLK pulses.
- R3: When the eighth bit has been shifted, in either mode, status bit 7 becomes 1. In the same cycle the receive buffer takes the byte that was shifted in.
- R4: Status bit 7 clears only through a specific sequence: a status read that returns it as 1, followed by any access (read or write) to address 0. A data access with no preceding status read leaves it set.
- R5: If a byte completes while status bit 7 is still 1, status bit 5 (overrun) is set. The new byte is dropped and the receive buffer keeps its earlier value.
- R6: The overrun bit stays set until a status read. That read returns it as 1 and then clears it.
- R7: In master mode, a write to address 0 during an exchange is ignored and the byte on the wire is unchanged. Status bit 6 (write collision) is set, and the next status read clears it.
- R8: Timing follows SPI mode 0. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge.
- R9: In slave mode, bits shift only while `ss_n_in` is low. Bits are captured from `mosi_in` on rising `sclk_in` edges, most significant bit first. `miso_out` presents the shift register's top bit while `ss_n_in` is low and is 0 otherwise.
- R10: In slave mode, any edge on slave-select resets the bit count. A partial byte aborted this way produces no completion, and the next full byte is received intact.
- R11: In master mode, `sclk_out` rests low when no exchange is running. In slave mode, `sclk_out` and `mosi_out` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 selects bus master, 0 selects bus slave |
| cpu_sel | input | 1 | CPU access strobe, one cycle per access |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 1 | 0 selects the data address, 1 selects status |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register |
| sclk_out | output | 1 | SCLK driven in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in for master mode |
| sclk_in | input | 1 | External SCLK in slave mode |
| ss_n_in | input | 1 | Active-low slave-select in slave mode |
| mosi_in | input | 1 | Serial data in for slave mode |
| miso_out | output | 1 | Serial data out in slave mode |

## Verification
The bench builds the block with `HALF_DIV` = 3, an odd divider, instead of the default 4. Each SCLK phase then ends on a counter wrap that does not line up with a power of two. An exchange also finishes in about fifty clocks, which leaves room for several sequences: collision, overrun, double-access clearing and an aborted slave byte. The slave-mode model runs its SCLK well below the system clock, so the synchroniser delay falls inside each half period. The byte width stays at 8, as every status encoding assumes.

// File: rtl/spi_byte_port_pkg.sv
package spi_byte_port_pkg;
    localparam int BYTE_W   = 8;
    localparam int ST_DONE  = 7;
    localparam int ST_WCOL  = 6;
    localparam int ST_OVR   = 5;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == CW'(HALF_DIV - 1));
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic ss_n_raw,
    input  logic mosi_raw,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic ss_edge,
    output logic ss_n_s,
    output logic mosi_s
);
    typedef struct packed {
        logic [2:0] sclk_p;
        logic [2:0] ss_p;
        logic [1:0] mosi_p;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.sclk_p = {st_q.sclk_p[1:0], sclk_raw};
        st_d.ss_p   = {st_q.ss_p[1:0], ss_n_raw};
        st_d.mosi_p = {st_q.mosi_p[0], mosi_raw};
        sclk_rise = st_q.sclk_p[1] & ~st_q.sclk_p[2];
        sclk_fall = ~st_q.sclk_p[1] & st_q.sclk_p[2];
        ss_edge   = st_q.ss_p[1] ^ st_q.ss_p[2];
        ss_n_s    = st_q.ss_p[1];
        mosi_s    = st_q.mosi_p[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_p <= '0;
            st_q.ss_p   <= '1;
            st_q.mosi_p <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master_mode,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tick,
    input  logic         miso_bit,
    input  logic         s_rise,
    input  logic         s_fall,
    input  logic         s_ss_edge,
    input  logic         s_ss_n,
    input  logic         s_mosi,
    output logic         ser_out,
    output logic         sclk,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int BW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  shreg;
        logic          smp;
        logic [BW-1:0] bits;
        logic          sclk;
        logic          busy;
        logic          done;
    } sh_t;

    sh_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (master_mode) begin
            if (load && !st_q.busy) begin
                st_d.shreg = load_data;
                st_d.busy  = 1'b1;
                st_d.bits  = '0;
                st_d.sclk  = 1'b0;
            end else if (st_q.busy && tick) begin
                if (!st_q.sclk) begin
                    st_d.sclk = 1'b1;
                    st_d.smp  = miso_bit;
                end else begin
                    st_d.sclk  = 1'b0;
                    st_d.shreg = {st_q.shreg[W-2:0], st_q.smp};
                    if (st_q.bits == BW'(W - 1)) begin
                        st_d.bits = '0;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.bits = st_q.bits + 1'b1;
                    end
                end
            end
        end else begin
            st_d.busy = 1'b0;
            st_d.sclk = 1'b0;
            if (load) begin
                st_d.shreg = load_data;
            end
            if (s_ss_edge) begin
                st_d.bits = '0;
            end else if (!s_ss_n) begin
                if (s_rise) begin
                    st_d.smp = s_mosi;
                end else if (s_fall) begin
                    if (!load) st_d.shreg = {st_q.shreg[W-2:0], st_q.smp};
                    if (st_q.bits == BW'(W - 1)) begin
                        st_d.bits = '0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.bits = st_q.bits + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_out = st_q.shreg[W-1];
    assign sclk    = st_q.sclk;
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign rx_byte = st_q.shreg;

    // R8: shift register frozen while master SCLK is high
    a_r8_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && st_q.busy && st_q.sclk) |-> $stable(st_q.shreg));
    // R11: idle master keeps SCLK low
    a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy) |-> !st_q.sclk);
    // R10: slave-select edge restarts the bit count
    a_r10_ss_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && s_ss_edge) |=> (st_q.bits == '0));
endmodule

// File: rtl/spi_status_regs.sv
module spi_status_regs
    import spi_byte_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic              cpu_addr,
    input  logic              xfer_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              wcol_evt,
    output logic [BYTE_W-1:0] rbuf,
    output logic [BYTE_W-1:0] status
);
    typedef struct packed {
        logic [BYTE_W-1:0] rbuf;
        logic              done;
        logic              ovr;
        logic              wcol;
        logic              armed;
    } rg_t;

    rg_t  st_d, st_q;
    logic stat_rd, data_acc, clear_done;

    always_comb begin
        st_d       = st_q;
        stat_rd    = cpu_sel && !cpu_we && (cpu_addr == ADDR_STAT);
        data_acc   = cpu_sel && (cpu_addr == ADDR_DATA);
        clear_done = data_acc && st_q.armed;

        if (clear_done) begin
            st_d.done  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (stat_rd) begin
            st_d.ovr  = 1'b0;
            st_d.wcol = 1'b0;
            if (st_q.done) st_d.armed = 1'b1;
        end
        if (xfer_done) begin
            if (st_d.done) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.rbuf = rx_byte;
                st_d.done = 1'b1;
            end
        end
        if (wcol_evt) st_d.wcol = 1'b1;

        status          = '0;
        status[ST_DONE] = st_q.done;
        status[ST_WCOL] = st_q.wcol;
        status[ST_OVR]  = st_q.ovr;
        rbuf            = st_q.rbuf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a completed byte always leaves the flag set
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> st_q.done);
    // R5: overrun keeps the earlier byte
    a_r5_keep_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && st_q.done && !clear_done) |=> (st_q.ovr && $stable(st_q.rbuf)));
    // R4: an unarmed data access does not clear the flag
    a_r4_needs_arming: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !st_q.armed && st_q.done) |=> st_q.done);
    // R6: overrun is sticky until a status read
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && st_q.ovr) |=> st_q.ovr);
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_byte_port_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic              cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              sclk_out,
    output logic              mosi_out,
    input  logic              miso_in,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    output logic              miso_out
);
    logic              tick, busy, done, ser_out, sclk_int;
    logic              s_rise, s_fall, s_ss_edge, s_ss_n, s_mosi;
    logic              wr_data, wcol_evt;
    logic [BYTE_W-1:0] rx_byte, rbuf, status;

    assign wr_data  = cpu_sel && cpu_we && (cpu_addr == ADDR_DATA);
    assign wcol_evt = wr_data && master_mode && busy;

    spi_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    spi_slave_sync u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_raw(sclk_in), .ss_n_raw(ss_n_in), .mosi_raw(mosi_in),
        .sclk_rise(s_rise), .sclk_fall(s_fall), .ss_edge(s_ss_edge),
        .ss_n_s(s_ss_n), .mosi_s(s_mosi)
    );

    spi_shift_core #(.W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .load(wr_data), .load_data(cpu_wdata), .tick(tick),
        .miso_bit(miso_in), .s_rise(s_rise), .s_fall(s_fall),
        .s_ss_edge(s_ss_edge), .s_ss_n(s_ss_n), .s_mosi(s_mosi),
        .ser_out(ser_out), .sclk(sclk_int), .busy(busy), .done(done),
        .rx_byte(rx_byte)
    );

    spi_status_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .xfer_done(done), .rx_byte(rx_byte),
        .wcol_evt(wcol_evt), .rbuf(rbuf), .status(status)
    );

    always_comb begin
        cpu_rdata = (cpu_addr == ADDR_STAT) ? status : rbuf;
        sclk_out  = master_mode & sclk_int;
        mosi_out  = master_mode & ser_out;
        miso_out  = ~master_mode & ~ss_n_in & ser_out;
    end

    // R7: a write during a master exchange raises write collision
    a_r7_wcol: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && master_mode && busy) |=> status[ST_WCOL]);
    // R11: slave mode never drives SCLK or MOSI
    a_r11_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!sclk_out && !mosi_out));
endmodule

// File: tb/spi_byte_port_test.sv
module spi_byte_port_test;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_mode = 1'b1;
    logic       cpu_sel = 1'b0, cpu_we = 1'b0, cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       sclk_out, mosi_out, miso_out;
    logic       miso_in = 1'b0, sclk_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;

    int  n_vec = 0, n_bad = 0;
    bit  finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // bench slave model for master mode
    logic [7:0] smodel = '0, mcap = '0;
    int         rises = 0, mviol = 0;
    logic       prev_sclk = 1'b0, prev_mosi = 1'b0;

    spi_byte_port #(.HALF_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sclk_out(sclk_out), .mosi_out(mosi_out), .miso_in(miso_in),
        .sclk_in(sclk_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in),
        .miso_out(miso_out)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (sclk_out && !prev_sclk) begin
            mcap  <= {mcap[6:0], mosi_out};
            rises <= rises + 1;
        end
        if (sclk_out && prev_sclk && (mosi_out != prev_mosi)) mviol <= mviol + 1;
        if (!sclk_out && prev_sclk) begin
            smodel  <= {smodel[6:0], 1'b0};
            miso_in <= smodel[6];
        end
        prev_sclk <= sclk_out;
        prev_mosi <= mosi_out;
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(logic a, logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(logic a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    // driver side: push expected receive-buffer contents
    task automatic expect_byte(string tag, logic [7:0] b);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    // monitor side: read buffer and pop the scoreboard
    task automatic pop_buffer();
        logic [7:0] d;
        cpu_read(1'b0, d);
        if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard empty: got %h expected none", d);
        end else begin
            check(tag_q.pop_front(), d, exp_q.pop_front());
        end
    endtask

    task automatic arm_model(logic [7:0] b);
        @(negedge clk);
        smodel = b; miso_in = b[7]; rises = 0; mviol = 0;
    endtask

    task automatic ext_bit(logic b, output logic got);
        mosi_in = b;
        repeat (8) @(negedge clk);
        sclk_in = 1'b1;
        got = miso_out;
        repeat (8) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    task automatic ext_byte(logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            logic g;
            ext_bit(b[i], g);
            got[i] = g;
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, got;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", cpu_rdata, 8'h00);
        cpu_read(1'b1, d); check("R1 status read", d, 8'h00);
        cpu_read(1'b0, d); check("R1 buffer", d, 8'h00);
        check("R1 pins", {5'b0, sclk_out, mosi_out, miso_out}, 8'h00);
        rst_n = 1'b1;

        // R2 R3 master exchange
        arm_model(8'h3C);
        expect_byte("R3 master rx", 8'h3C);
        cpu_write(1'b0, 8'hA5);
        repeat (70) @(negedge clk);
        check("R2 mosi byte", mcap, 8'hA5);
        check("R2 pulses", 8'(rises), 8'd8);
        check("R8 mosi stable while sclk high", 8'(mviol), 8'd0);
        check("R11 idle sclk", {7'b0, sclk_out}, 8'h00);
        // R4 unarmed data read keeps flag
        pop_buffer();
        cpu_read(1'b1, d); check("R4 still set", d, 8'h80);
        expect_byte("R4 buffer", 8'h3C);
        pop_buffer();
        cpu_read(1'b1, d); check("R4 cleared", d, 8'h00);

        // R7 collision
        arm_model(8'hC3);
        expect_byte("R7 rx", 8'hC3);
        cpu_write(1'b0, 8'h5A);
        repeat (10) @(negedge clk);
        cpu_write(1'b0, 8'hFF);
        repeat (70) @(negedge clk);
        check("R7 wire byte unchanged", mcap, 8'h5A);
        cpu_read(1'b1, d); check("R7 wcol", d, 8'hC0);
        pop_buffer();
        cpu_read(1'b1, d); check("R7 wcol cleared", d, 8'h00);

        // R5 R6 overrun
        arm_model(8'h11);
        expect_byte("R5 kept byte", 8'h11);
        cpu_write(1'b0, 8'h01);
        repeat (70) @(negedge clk);
        arm_model(8'h22);
        cpu_write(1'b0, 8'h02);
        repeat (70) @(negedge clk);
        check("R2 second byte", mcap, 8'h02);
        cpu_read(1'b0, d); check("R5 buffer kept", d, 8'h11);
        cpu_read(1'b1, d); check("R6 overrun seen", d, 8'hA0);
        pop_buffer();
        cpu_read(1'b1, d); check("R6 overrun cleared", d, 8'h00);

        // R9 slave mode
        master_mode = 1'b0;
        cpu_write(1'b0, 8'h96);
        check("R9 miso idle", {7'b0, miso_out}, 8'h00);
        check("R11 slave quiet", {6'b0, sclk_out, mosi_out}, 8'h00);
        @(negedge clk); ss_n_in = 1'b0;
        repeat (8) @(negedge clk);
        expect_byte("R9 slave rx", 8'h6D);
        ext_byte(8'h6D, got);
        check("R9 miso byte", got, 8'h96);
        ss_n_in = 1'b1;
        repeat (8) @(negedge clk);
        cpu_read(1'b1, d); check("R3 slave flag", d, 8'h80);
        pop_buffer();

        // R10 aborted partial byte
        ss_n_in = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            logic g;
            ext_bit(1'b1, g);
        end
        ss_n_in = 1'b1;
        repeat (8) @(negedge clk);
        ss_n_in = 1'b0;
        repeat (8) @(negedge clk);
        expect_byte("R10 full byte", 8'h4E);
        ext_byte(8'h4E, got);
        ss_n_in = 1'b1;
        repeat (8) @(negedge clk);
        cpu_read(1'b1, d); check("R10 one completion", d, 8'h80);
        pop_buffer();
        cpu_read(1'b1, d); check("R10 cleared", d, 8'h00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule